// File: doc/BRIEF.md
# Outbound Doorbell Interrupt Mapper

This block holds a 32-bit outbound doorbell. Device-side logic raises doorbell bits with a one-cycle set pulse vector. The host lowers them through a small register bus by writing ones to a clear register. A mask register blocks individual bits. Pending, unmasked bits become host interrupt requests in one of three modes. Per-vector message mode gives 32 vectors. Folded message mode gives 16 vectors, with doorbell bits n and n+16 sharing vector n. Legacy mode drives a single level-sensitive line.

In the two message modes, a one-cycle request carrying a vector index is issued each time a vector's unmasked pending condition rises. When several vectors rise together, they wait in a pending set and are issued one per cycle, lowest index first. A queued vector whose condition falls before its turn is dropped. In legacy mode the line stays high while any unmasked bit is pending. It drops only when the host has cleared or masked every such bit.

Top module: `obd_irq_mapper`

## Requirements
- R1: After reset the doorbell reads 0, the mask reads all ones, `msg_req_o` is 0 and `intx_o` is 0.
- R2: A 1 in `set_i` sets the matching doorbell bit at the next clock edge. A read at offset 0x3C returns the raw doorbell regardless of the mask, and writes to 0x3C are ignored.
- R3: Writing to offset 0x40 clears each doorbell bit whose write data bit is 1. Bits written 0 are unchanged, and 0x40 reads back as 0.
- R4: When `set_i` and a clear write hit the same bit in the same cycle, the bit ends up set.
- R5: The mask at offset 0x74 is read/write. A masked bit raises neither a request nor `intx_o`. Offset 0x44 reads the doorbell ANDed with the inverted mask.
- R6: `mode_i` is encoded as 0 per-vector message, 1 folded message, 2 legacy level and 3 off. Offset 0x48 returns the mode in bits [1:0]. Mode 3 raises no request and no level.
- R7: In mode 0, a rising unmasked pending bit i gives `msg_req_o`=1 with `msg_vec_o`=i for exactly one cycle. This happens in the cycle after the first clock edge that follows the doorbell update.
- R8: In mode 1, vector n (0..15) is pending when unmasked bit n or unmasked bit n+16 is pending. Setting the second bit of a vector that is already pending raises no new request.
- R9: Vectors that rise in the same cycle are issued one per cycle in ascending index order.
- R10: In mode 2, `intx_o` is high exactly while some unmasked doorbell bit is pending, and no message requests are issued.
- R11: Clearing the mask bit of an already pending doorbell bit in a message mode issues a request for its vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Interrupt mode select |
| set_i | input | 32 | Device-side doorbell set pulses |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| msg_req_o | output | 1 | One-cycle message interrupt request |
| msg_vec_o | output | 5 | Vector index of the request |
| intx_o | output | 1 | Legacy level interrupt |

## Verification
A single set pulse shows the request latency and the one-shot behaviour. Three bits set in the same cycle separate ascending issue from any other order. Setting bits 5 and 21 together and then clearing bit 5 in folded mode shows that the fold merges the pair into one vector and does not re-trigger while the vector stays pending. A set that collides with a clear, a set under the reset mask followed by an unmask, and legacy-mode mask and clear sequences separate set priority, the raw versus filtered readback and the level behaviour of the legacy line.

// File: rtl/obd_pkg.sv
package obd_pkg;
  typedef enum logic [1:0] {
    MODE_MSI  = 2'd0,
    MODE_MSIX = 2'd1,
    MODE_INTX = 2'd2,
    MODE_OFF  = 2'd3
  } irq_mode_e;

  localparam logic [7:0] OFS_DB   = 8'h3C;
  localparam logic [7:0] OFS_CLR  = 8'h40;
  localparam logic [7:0] OFS_STAT = 8'h44;
  localparam logic [7:0] OFS_MODE = 8'h48;
  localparam logic [7:0] OFS_MASK = 8'h74;
endpackage

// File: rtl/obd_regs.sv
module obd_regs
  import obd_pkg::*;
#(
  parameter int DB_W   = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [DB_W-1:0]   set_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DB_W-1:0]   wdata_i,
  output logic [DB_W-1:0]   rdata_o,
  output logic [DB_W-1:0]   um_o
);
  logic [DB_W-1:0] db_q, mask_q, clr_v;
  logic            clr_hit, mask_hit;

  assign clr_hit  = we_i && (addr_i == ADDR_W'(OFS_CLR));
  assign mask_hit = we_i && (addr_i == ADDR_W'(OFS_MASK));
  assign clr_v    = clr_hit ? wdata_i : '0;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      db_q   <= '0;
      mask_q <= '1;
    end else begin
      db_q <= (db_q & ~clr_v) | set_i;
      if (mask_hit) mask_q <= wdata_i;
    end
  end

  assign um_o = db_q & ~mask_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_DB))        rdata_o = db_q;
    else if (addr_i == ADDR_W'(OFS_STAT)) rdata_o = um_o;
    else if (addr_i == ADDR_W'(OFS_MODE)) rdata_o = DB_W'(mode_i);
    else if (addr_i == ADDR_W'(OFS_MASK)) rdata_o = mask_q;
  end

  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((db_q & $past(set_i)) == $past(set_i)));

  a_r3_clear_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_hit |=> ((db_q & $past(wdata_i) & ~$past(set_i)) == '0));

  a_r2_rise_only_by_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((db_q & ~$past(db_q) & ~$past(set_i)) == '0));
endmodule

// File: rtl/obd_vec_fold.sv
module obd_vec_fold
  import obd_pkg::*;
#(
  parameter int DB_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      mode_i,
  input  logic [DB_W-1:0] um_i,
  output logic [DB_W-1:0] cond_o
);
  localparam int HALF = DB_W / 2;

  logic [DB_W-1:0] folded;

  for (genvar i = 0; i < DB_W; i++) begin : g_fold
    if (i < HALF) begin : g_lo
      assign folded[i] = um_i[i] | um_i[i+HALF];
    end else begin : g_hi
      assign folded[i] = 1'b0;
    end
  end

  always_comb begin
    unique case (irq_mode_e'(mode_i))
      MODE_MSI:  cond_o = um_i;
      MODE_MSIX: cond_o = folded;
      default:   cond_o = '0;
    endcase
  end

  a_r8_upper_vectors_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_MSIX) |-> (cond_o[DB_W-1:HALF] == '0));

  a_r8_pair_merged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == MODE_MSIX) && (um_i[HALF-1:0] != '0 || um_i[DB_W-1:HALF] != '0))
      |-> (cond_o != '0));
endmodule

// File: rtl/obd_msg_queue.sv
module obd_msg_queue #(
  parameter int DB_W  = 32,
  parameter int VEC_W = $clog2(DB_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DB_W-1:0]  cond_i,
  output logic             req_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [DB_W-1:0]  cond_q, pend_q, live, grant;
  logic [VEC_W-1:0] sel;
  logic             found;

  assign live = pend_q & cond_i;

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < DB_W; i++) begin
      if (live[i] && !found) begin
        sel   = VEC_W'(i);
        found = 1'b1;
      end
    end
  end

  assign grant = found ? (DB_W'(1) << sel) : '0;

  // entries whose condition drops before issue are discarded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= '0;
      pend_q <= '0;
    end else begin
      cond_q <= cond_i;
      pend_q <= ((pend_q & ~grant) | (cond_i & ~cond_q)) & cond_i;
    end
  end

  assign req_o = found;
  assign vec_o = sel;

  a_r7_req_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> cond_i[vec_o]);

  a_r7_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !(req_o && vec_o == $past(vec_o)));
endmodule

// File: rtl/obd_irq_mapper.sv
module obd_irq_mapper
  import obd_pkg::*;
#(
  parameter int DB_W   = 32,
  parameter int ADDR_W = 8,
  localparam int VEC_W = $clog2(DB_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [DB_W-1:0]   set_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DB_W-1:0]   reg_wdata_i,
  output logic [DB_W-1:0]   reg_rdata_o,
  output logic              msg_req_o,
  output logic [VEC_W-1:0]  msg_vec_o,
  output logic              intx_o
);
  logic [DB_W-1:0] um, cond;

  obd_regs #(.DB_W(DB_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_i),
    .set_i   (set_i),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .um_o    (um)
  );

  obd_vec_fold #(.DB_W(DB_W)) u_fold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .um_i   (um),
    .cond_o (cond)
  );

  obd_msg_queue #(.DB_W(DB_W), .VEC_W(VEC_W)) u_queue (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cond_i (cond),
    .req_o  (msg_req_o),
    .vec_o  (msg_vec_o)
  );

  assign intx_o = (mode_i == MODE_INTX) && (um != '0);

  a_r10_no_msg_in_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_INTX || mode_i == MODE_OFF) |-> !msg_req_o);

  a_r6_no_level_in_msg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_INTX) |-> !intx_o);
endmodule

// File: tb/tb_obd_irq_mapper.sv
`timescale 1ns/1ps
module tb_obd_irq_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [31:0] set_v = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        req;
  logic [4:0]  vec;
  logic        intx;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  obd_irq_mapper dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .set_i(set_v),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .msg_req_o(req), .msg_vec_o(vec), .intx_o(intx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse(input logic [31:0] v);
    set_v = v;
    tick();
    set_v = '0;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    rd(8'h3C, r); chk("R1 doorbell", r, 32'h0);
    rd(8'h74, r); chk("R1 mask", r, 32'hFFFF_FFFF);
    chk("R1 req", {31'b0, req}, 32'h0);
    chk("R1 intx", {31'b0, intx}, 32'h0);
  endtask

  task automatic t_mask_and_regs();
    logic [31:0] r;
    mode = 2'd0;
    pulse(32'h4);
    tick();
    chk("R5 masked no req", {31'b0, req}, 32'h0);
    rd(8'h3C, r); chk("R2 raw doorbell", r, 32'h4);
    rd(8'h44, r); chk("R5 status masked", r, 32'h0);
    wr(8'h74, 32'h0);
    rd(8'h74, r); chk("R5 mask readback", r, 32'h0);
    rd(8'h44, r); chk("R5 status unmasked", r, 32'h4);
    chk("R11 not yet", {31'b0, req}, 32'h0);
    tick();
    chk("R11 unmask req", {26'b0, req, vec}, {26'b0, 1'b1, 5'd2});
    tick();
    chk("R7 one shot", {31'b0, req}, 32'h0);
    wr(8'h3C, 32'hFFFF_FFFF);
    rd(8'h3C, r); chk("R2 write ignored", r, 32'h4);
    wr(8'h40, 32'h0);
    rd(8'h3C, r); chk("R3 zero no effect", r, 32'h4);
    wr(8'h40, 32'h4);
    rd(8'h3C, r); chk("R3 w1c", r, 32'h0);
    rd(8'h40, r); chk("R3 clear reads 0", r, 32'h0);
  endtask

  task automatic t_msi_order();
    logic [31:0] r;
    pulse(32'h0010_0088);
    chk("R7 latency", {31'b0, req}, 32'h0);
    tick(); chk("R9 first", {26'b0, req, vec}, {26'b0, 1'b1, 5'd3});
    tick(); chk("R9 second", {26'b0, req, vec}, {26'b0, 1'b1, 5'd7});
    tick(); chk("R9 third", {26'b0, req, vec}, {26'b0, 1'b1, 5'd20});
    tick(); chk("R9 drained", {31'b0, req}, 32'h0);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h3C, r); chk("R3 all cleared", r, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] r;
    set_v = 32'h200;
    wr(8'h40, 32'h200);
    set_v = '0;
    rd(8'h3C, r); chk("R4 set wins", r, 32'h200);
    tick(); tick();
    wr(8'h40, 32'h200);
    tick();
  endtask

  task automatic t_msix();
    logic [31:0] r;
    mode = 2'd1;
    rd(8'h48, r); chk("R6 mode readback", r, 32'h1);
    pulse(32'h0020_0020);
    tick(); chk("R8 folded vec", {26'b0, req, vec}, {26'b0, 1'b1, 5'd5});
    tick(); chk("R8 single req", {31'b0, req}, 32'h0);
    wr(8'h40, 32'h20);
    tick(); chk("R8 still pending no req", {31'b0, req}, 32'h0);
    pulse(32'h4000_0000);
    tick(); chk("R8 upper bit vec", {26'b0, req, vec}, {26'b0, 1'b1, 5'd14});
    wr(8'h40, 32'hFFFF_FFFF);
    tick();
  endtask

  task automatic t_level();
    logic [31:0] r;
    mode = 2'd2;
    pulse(32'h1000);
    chk("R10 level high", {31'b0, intx}, 32'h1);
    tick(); chk("R10 no msg", {31'b0, req}, 32'h0);
    wr(8'h74, 32'h1000);
    chk("R10 masked low", {31'b0, intx}, 32'h0);
    wr(8'h74, 32'h0);
    chk("R10 unmasked high", {31'b0, intx}, 32'h1);
    wr(8'h40, 32'h1000);
    chk("R10 cleared low", {31'b0, intx}, 32'h0);
    mode = 2'd3;
    rd(8'h48, r); chk("R6 off readback", r, 32'h3);
    pulse(32'h8);
    tick();
    chk("R6 off no level", {31'b0, intx}, 32'h0);
    chk("R6 off no msg", {31'b0, req}, 32'h0);
    wr(8'h40, 32'h8);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_mask_and_regs();
    t_msi_order();
    t_set_wins();
    t_msix();
    t_level();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule